// File: doc/BRIEF.md
# Cycle-Steal Boot Image Loader

This block places a fixed bootstrap image into the lowest words of a host's main memory through a cycle-steal write port. It runs inside the short window that opens when the host is forced through a reset and closes when an external start action makes the host execute the image.

Once armed by a start strobe, the loader does nothing until it has watched one complete reset pulse on the host's reset-state level, first active and then inactive again. Only then does it begin writing. The image is 80 sixteen-bit words, one per column of a punched boot card. They go to word addresses 0x0000 to 0x004F in ascending order, and each word takes one request/acknowledge handshake.

If the host re-enters reset partway through, the partial load is dropped and the loader waits for the reset to clear before it starts again from the first word. When the final word is acknowledged, the loader raises a done flag and keeps it high until it is armed again. The image sits in an internal register array that is filled through a simple write port before arming.

Top module: `boot_loader`

## Requirements
- R1: After reset, `cs_req` and `done` are low. Host reset pulses that arrive before `arm` never cause a request.
- R2: After `arm`, no request is made until `host_rst` has been seen high and then low. The first request, at address 0x0000, appears in the cycle after `host_rst` is sampled low following that high phase.
- R3: While `cs_req` is high and `cs_ack` is low, `cs_addr` and `cs_data` hold their values.
- R4: The words are written to consecutive addresses 0x0000 through 0x004F. The data at address A is image entry A, and the address advances by one in the cycle after each acknowledge.
- R5: In the cycle after the word at 0x004F is acknowledged, `cs_req` is low and `done` is high. `done` then stays high, with no request, until `arm` is pulsed.
- R6: If `host_rst` is high during a transfer, `cs_req` drops in the next cycle and the acknowledge in that cycle is ignored. After `host_rst` falls, the load restarts at address 0x0000.
- R7: Pulsing `arm` while `done` is high clears `done` in the next cycle. A full new load then runs after the next complete host reset pulse.
- R8: With `cs_ack` held high, one word is written per cycle, so `cs_req` is high for exactly 80 cycles.
- R9: A write on the fill port (`fill_we`, with entry index `fill_idx` and value `fill_word`) sets the image entry that is later sent to address `fill_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start strobe, one cycle |
| host_rst | input | 1 | Host reset-state level, high while the host is in reset |
| cs_ack | input | 1 | Cycle-steal acknowledge for the current word |
| fill_we | input | 1 | Image entry write enable |
| fill_idx | input | 7 | Image entry index |
| fill_word | input | 16 | Image entry value |
| cs_req | output | 1 | Cycle-steal write request |
| cs_addr | output | 16 | Word address of the current write |
| cs_data | output | 16 | Data of the current write |
| done | output | 1 | The full image has been written |

## Verification
The bench first steps through the arming sequence one cycle at a time. It includes a reset pulse before arming, which a loader that skipped the arm gate would act on. It also checks that the loader does not start on the reset rising edge, which a design watching only the level would do. During the load, acknowledges arrive after varying delays to catch an address that moves before its acknowledge. A reset that arrives together with an acknowledge in the middle of a load must send the restart back to address zero and not to the next word. The last-word boundary is checked for a missing or extra write, and a back-to-back run with the acknowledge held high exposes a pipeline bubble.

// File: rtl/boot_loader.sv
module boot_loader #(
  parameter int WORDS = 80,
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int BASE  = 0,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          host_rst,
  input  logic          cs_ack,
  input  logic          fill_we,
  input  logic [IW-1:0] fill_idx,
  input  logic [DW-1:0] fill_word,
  output logic          cs_req,
  output logic [AW-1:0] cs_addr,
  output logic [DW-1:0] cs_data,
  output logic          done
);
  typedef enum logic [2:0] {S_IDLE, S_ARMED, S_INRST, S_XFER, S_DONE} state_t;

  state_t        state;
  logic [IW-1:0] idx;
  logic [DW-1:0] img [WORDS];

  wire last  = (int'(idx) == WORDS - 1);
  wire taken = cs_req && cs_ack && !host_rst;

  always_ff @(posedge clk) begin
    if (fill_we && int'(fill_idx) < WORDS) img[fill_idx] <= fill_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (arm) state <= S_ARMED;
        S_ARMED:        if (host_rst) state <= S_INRST;
        S_INRST:        if (!host_rst) begin
                          state <= S_XFER;
                          idx   <= '0;
                        end
        S_XFER: begin
          if (host_rst) begin
            state <= S_INRST;
          end else if (taken) begin
            if (last) state <= S_DONE;
            else      idx   <= idx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cs_req  = (state == S_XFER);
  assign done    = (state == S_DONE);
  assign cs_addr = AW'(BASE) + AW'(idx);
  assign cs_data = img[idx];
endmodule

module boot_loader_chk #(
  parameter int WORDS = 80,
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int BASE  = 0,
  localparam int IW   = $clog2(WORDS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          host_rst,
  input logic          cs_ack,
  input logic          cs_req,
  input logic [AW-1:0] cs_addr,
  input logic [DW-1:0] cs_data,
  input logic          done
);
  localparam logic [AW-1:0] LAST_A = AW'(BASE + WORDS - 1);
  localparam logic [AW-1:0] FIRST_A = AW'(BASE);

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_req && done));

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_req) |-> ($past(!host_rst) && cs_addr == FIRST_A));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_req && !cs_ack && !host_rst) |=> (cs_req && $stable(cs_addr) && $stable(cs_data)));

  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_req |-> (cs_addr >= FIRST_A && cs_addr <= LAST_A));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_req && cs_ack && !host_rst && cs_addr != LAST_A) |=> (cs_req && cs_addr == $past(cs_addr) + 1'b1));

  p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_req && cs_ack && !host_rst && cs_addr == LAST_A) |=> (done && !cs_req));

  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_req && host_rst) |=> (!cs_req && !done));

  p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && arm) |=> (!done && !cs_req));
endmodule

bind boot_loader boot_loader_chk #(.WORDS(WORDS), .AW(AW), .DW(DW), .BASE(BASE)) u_chk (.*);

// File: tb/boot_loader_bench.sv
module boot_loader_bench;
  localparam int WORDS = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, host_rst = 1'b0, cs_ack = 1'b0;
  logic fill_we = 1'b0;
  logic [6:0]  fill_idx = '0;
  logic [15:0] fill_word = '0;
  logic cs_req, done;
  logic [15:0] cs_addr, cs_data;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  boot_loader u_boot_loader (
    .clk(clk), .rst_n(rst_n), .arm(arm), .host_rst(host_rst), .cs_ack(cs_ack),
    .fill_we(fill_we), .fill_idx(fill_idx), .fill_word(fill_word),
    .cs_req(cs_req), .cs_addr(cs_addr), .cs_data(cs_data), .done(done));

  function automatic logic [15:0] img_val(int i);
    return 16'hA500 ^ 16'(i * 16'h0137);
  endfunction

  // {arm, host_rst, expected req, expected done, expected addr}
  localparam logic [19:0] VEC [9] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b0, 1'b0, 1'b1, 1'b0, 16'h0000},
    {1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b0, 1'b0, 1'b1, 1'b0, 16'h0000}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_reset();
    host_rst = 1'b1; step();
    host_rst = 1'b0; step();
  endtask

  task automatic run_load(input int first);
    for (int i = first; i < WORDS; i++) begin
      chk(cs_req == 1'b1, "R4 req", 32'(cs_req), 1);
      chk(cs_addr == 16'(i), "R4 addr", 32'(cs_addr), 32'(i));
      chk(cs_data == img_val(i), "R4 R9 data", 32'(cs_data), 32'(img_val(i)));
      for (int d = 0; d < i % 3; d++) begin
        step();
        chk(cs_req && cs_addr == 16'(i) && cs_data == img_val(i), "R3 hold",
            32'(cs_addr), 32'(i));
      end
      cs_ack = 1'b1; step(); cs_ack = 1'b0;
    end
    chk(done == 1'b1 && cs_req == 1'b0, "R5 finish", {cs_req, done}, 32'b01);
  endtask

  initial begin
    repeat (3) step();
    chk(cs_req == 1'b0 && done == 1'b0, "R1 reset state", {cs_req, done}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < WORDS; i++) begin
      fill_we = 1'b1; fill_idx = 7'(i); fill_word = img_val(i); step();
    end
    fill_we = 1'b0;

    foreach (VEC[k]) begin
      arm = VEC[k][19]; host_rst = VEC[k][18];
      step();
      arm = 1'b0;
      chk(cs_req == VEC[k][17] && done == VEC[k][16], "R1 R2 R6 sequence",
          {cs_req, done}, {VEC[k][17], VEC[k][16]});
      if (VEC[k][17])
        chk(cs_addr == VEC[k][15:0], "R2 first addr", 32'(cs_addr), 32'(VEC[k][15:0]));
    end

    run_load(0);
    repeat (4) step();
    chk(done == 1'b1 && cs_req == 1'b0, "R5 done held", {cs_req, done}, 32'b01);
    host_rst = 1'b1; step(); host_rst = 1'b0; step();
    chk(done == 1'b1 && cs_req == 1'b0, "R5 reset while done", {cs_req, done}, 32'b01);

    arm = 1'b1; step(); arm = 1'b0;
    chk(done == 1'b0 && cs_req == 1'b0, "R7 rearm clears", {cs_req, done}, 0);
    pulse_reset();
    chk(cs_req == 1'b1 && cs_addr == 16'h0, "R7 reload start", 32'(cs_addr), 0);

    cs_ack = 1'b1;
    repeat (10) step();
    chk(cs_addr == 16'd10, "R8 midway addr", 32'(cs_addr), 10);
    host_rst = 1'b1; step();
    cs_ack = 1'b0;
    chk(cs_req == 1'b0 && done == 1'b0, "R6 abort", {cs_req, done}, 0);
    step();
    chk(cs_req == 1'b0, "R6 wait in reset", 32'(cs_req), 0);
    host_rst = 1'b0; step();
    chk(cs_req == 1'b1 && cs_addr == 16'h0, "R6 restart at zero", 32'(cs_addr), 0);

    begin
      int cnt = 0;
      cs_ack = 1'b1;
      while (cs_req && cnt < 200) begin
        cnt++;
        step();
      end
      cs_ack = 1'b0;
      chk(cnt == WORDS, "R8 back-to-back count", 32'(cnt), 32'(WORDS));
      chk(done == 1'b1, "R8 done after run", 32'(done), 1);
    end

    arm = 1'b1; step(); arm = 1'b0;
    pulse_reset();
    run_load(0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule